// File: doc/BRIEF.md
# Dual-Mode Packet Bus Receive Checker

This block sits on the receive side of a transmit-direction packet bus. The bus runs in one of two layouts, chosen by a configuration input. In the wide layout it is a single 32-bit lane shared by four ports, with one set of control bits. In the narrow layout it is four independent 8-bit lanes, and each lane has its own parity, enable, start, end and error bits. The block qualifies each beat with the write enable and checks its parity. It tracks packet framing for each port or lane and forwards the accepted beats as registered per-port words. Each word carries start, end, error and valid-byte indications, along with parity-error and framing-error pulses.

In the wide layout, a port-select cycle names the port that the following enabled beats belong to. A 2-bit modulo value on the closing beat gives the number of valid bytes in the last word. Parity sense (odd or even) is a configuration input. Parity errors are also held in sticky bits until they are cleared. The layout may only be changed while every lane is idle; a synchronous reset returns all framing state to idle.

Top module: `pkt_rx_checker`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every output is 0 and every port or lane is outside a packet. The wide-layout port select returns to port 0.
- R2: With `cfg_even_par`=0 (odd sense), a checked beat is in error when the count of ones over its data bits plus its parity bit is even. In the wide layout the data bits are `in_dat[31:0]` with `in_par[0]`. In the narrow layout lane i uses `in_dat[8i+7:8i]` with `in_par[i]`.
- R3: With `cfg_even_par`=1, a checked beat is in error when that count of ones is odd.
- R4: Parity is checked only in two cases: on a wide-layout cycle with `in_en[0]` or `in_stx` high, and on a narrow-layout cycle for lane i with `in_en[i]` high. On all other cycles the parity input has no effect. `in_stx` is ignored in the narrow layout.
- R5: In the wide layout only bit 0 of `in_par`, `in_en`, `in_sop`, `in_eop` and `in_err` is used. A parity error pulses `out_par_err[0]` only, and at most one `out_vld` bit is high in any cycle.
- R6: In the wide layout, a cycle with `in_stx`=1 and `in_en[0]`=0 is a port-select cycle. It makes `in_dat[1:0]` the current port and forwards no data. Each later enabled beat is reported on bit p of the per-port outputs, where p is the current port, and carries the whole 32-bit word on `out_dat`.
- R7: In the narrow layout each lane is independent. An accepted beat on lane i sets `out_vld[i]` and places its byte on `out_dat[8i+7:8i]`. Bytes of lanes that forward nothing read 0.
- R8: `out_err[p]` is high only for a forwarded beat that has end-of-packet, enable and error all high in the same cycle. An error bit on any other beat is dropped.
- R9: When the enable of a lane is low, that lane's data, sop, eop, error and modulo inputs are not consumed. Nothing is forwarded, no framing check runs and the framing state does not change.
- R10: On a forwarded wide-layout end beat, `out_mod` equals `in_mod`. The encoding is 00 for 4 valid bytes, 01 for 1, 10 for 2 and 11 for 3. On every other cycle, and always in the narrow layout, `out_mod` is 00.
- R11: A sop beat on a port already inside a packet pulses `out_frm_err` for that port, restarts the packet and is forwarded. A non-sop beat outside a packet pulses `out_frm_err` and is dropped. A beat with both sop and eop is a complete one-beat packet.
- R12: Each parity-error pulse also sets the matching bit of `out_par_sticky`. `clr_sticky` clears all the sticky bits, but a new error in the same cycle still sets its bit.
- R13: All outputs are registered. The effect of an input beat appears on the outputs exactly one clock later and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1: one 32-bit lane for four ports; 0: four 8-bit lanes |
| cfg_even_par | input | 1 | 1: even parity sense; 0: odd |
| clr_sticky | input | 1 | Clears the sticky parity bits |
| in_dat | input | 32 | Bus data |
| in_par | input | 4 | Parity bits (bit 0 only in the wide layout) |
| in_en | input | 4 | Write enables |
| in_stx | input | 1 | Port-select strobe (wide layout) |
| in_sop | input | 4 | Start-of-packet bits |
| in_eop | input | 4 | End-of-packet bits |
| in_err | input | 4 | Packet error bits |
| in_mod | input | 2 | Valid bytes in the last wide word |
| out_vld | output | 4 | Per-port forwarded beat |
| out_dat | output | 32 | Forwarded data |
| out_sop | output | 4 | Forwarded start |
| out_eop | output | 4 | Forwarded end |
| out_err | output | 4 | Packet error on the end beat |
| out_mod | output | 2 | Modulo on a wide end beat |
| out_frm_err | output | 4 | Framing-error pulse per port or lane |
| out_par_err | output | 4 | Parity-error pulse |
| out_par_sticky | output | 4 | Sticky parity-error bits |

## Verification
A wrong in-packet bit in a port tracker shows on the next beat sent to that port. It appears as a framing pulse that should not be there, or as a dropped or forwarded beat that should have gone the other way, one clock after that beat. A wrong port-select register routes the next enabled beat onto the wrong `out_vld` bit, one clock after it is driven. A sticky bit that is set wrongly stays visible on `out_par_sticky` until the next clear. For these reasons the bench runs long random streams in both layouts, with rare parity faults, and compares every output on every cycle.

// File: rtl/pkt_chk_pkg.sv
package pkt_chk_pkg;
  // One qualified beat as seen by a framing tracker
  typedef struct packed {
    logic vld;
    logic sop;
    logic eop;
  } beat_t;
endpackage

// File: rtl/pkt_par_check.sv
module pkt_par_check #(
  parameter int W = 8
) (
  input  logic [W-1:0] dat,
  input  logic         par,
  input  logic         even_sel,
  input  logic         qual,
  output logic         bad
);
  logic ones_odd;
  assign ones_odd = ^{dat, par};
  // odd sense wants an odd total, even sense an even total
  assign bad = qual & (ones_odd == even_sel);
endmodule

// File: rtl/pkt_frame_track.sv
module pkt_frame_track
  import pkt_chk_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  beat_t beat,
  output logic  fwd,
  output logic  frm_err
);
  logic inpkt_q, inpkt_d;

  always_comb begin
    fwd     = 1'b0;
    frm_err = 1'b0;
    inpkt_d = inpkt_q;
    if (beat.vld) begin
      if (beat.sop) begin
        fwd     = 1'b1;
        frm_err = inpkt_q;
        inpkt_d = ~beat.eop;
      end else begin
        fwd     = inpkt_q;
        frm_err = ~inpkt_q;
        if (beat.eop) inpkt_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) inpkt_q <= 1'b0;
    else     inpkt_q <= inpkt_d;
  end

  // R11
  open_only_on_sop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(inpkt_q) |-> $past(beat.vld & beat.sop));
endmodule

// File: rtl/pkt_rx_checker.sv
module pkt_rx_checker
  import pkt_chk_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_wide,
  input  logic                          cfg_even_par,
  input  logic                          clr_sticky,
  input  logic [NUM_LANES*LANE_W-1:0]   in_dat,
  input  logic [NUM_LANES-1:0]          in_par,
  input  logic [NUM_LANES-1:0]          in_en,
  input  logic                          in_stx,
  input  logic [NUM_LANES-1:0]          in_sop,
  input  logic [NUM_LANES-1:0]          in_eop,
  input  logic [NUM_LANES-1:0]          in_err,
  input  logic [$clog2(NUM_LANES)-1:0]  in_mod,
  output logic [NUM_LANES-1:0]          out_vld,
  output logic [NUM_LANES*LANE_W-1:0]   out_dat,
  output logic [NUM_LANES-1:0]          out_sop,
  output logic [NUM_LANES-1:0]          out_eop,
  output logic [NUM_LANES-1:0]          out_err,
  output logic [$clog2(NUM_LANES)-1:0]  out_mod,
  output logic [NUM_LANES-1:0]          out_frm_err,
  output logic [NUM_LANES-1:0]          out_par_err,
  output logic [NUM_LANES-1:0]          out_par_sticky
);
  localparam int BUS_W = NUM_LANES * LANE_W;
  localparam int PW    = $clog2(NUM_LANES);

  logic [PW-1:0]        cur_port;
  logic                 stx_take;
  logic                 wide_bad;
  logic [NUM_LANES-1:0] nar_bad, par_now, fwd, frm, sop_b, eop_b, err_b;
  beat_t                beat [NUM_LANES];

  assign stx_take = cfg_wide & in_stx & ~in_en[0];

  always_ff @(posedge clk) begin
    if (rst)           cur_port <= '0;
    else if (stx_take) cur_port <= in_dat[PW-1:0];
  end

  pkt_par_check #(.W(BUS_W)) u_par_wide (
    .dat(in_dat), .par(in_par[0]), .even_sel(cfg_even_par),
    .qual(cfg_wide & (in_en[0] | in_stx)), .bad(wide_bad)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    pkt_par_check #(.W(LANE_W)) u_par (
      .dat(in_dat[i*LANE_W +: LANE_W]), .par(in_par[i]), .even_sel(cfg_even_par),
      .qual(~cfg_wide & in_en[i]), .bad(nar_bad[i])
    );

    if (i == 0) begin : g_p0
      assign par_now[i] = cfg_wide ? wide_bad : nar_bad[i];
    end else begin : g_pn
      assign par_now[i] = ~cfg_wide & nar_bad[i];
    end

    assign beat[i].vld = cfg_wide ? (in_en[0] & (cur_port == PW'(i))) : in_en[i];
    assign beat[i].sop = cfg_wide ? in_sop[0] : in_sop[i];
    assign beat[i].eop = cfg_wide ? in_eop[0] : in_eop[i];
    assign sop_b[i]    = beat[i].sop;
    assign eop_b[i]    = beat[i].eop;
    assign err_b[i]    = cfg_wide ? in_err[0] : in_err[i];

    pkt_frame_track u_trk (
      .clk(clk), .rst(rst), .beat(beat[i]), .fwd(fwd[i]), .frm_err(frm[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld        <= '0;
      out_dat        <= '0;
      out_sop        <= '0;
      out_eop        <= '0;
      out_err        <= '0;
      out_mod        <= '0;
      out_frm_err    <= '0;
      out_par_err    <= '0;
      out_par_sticky <= '0;
    end else begin
      out_vld        <= fwd;
      out_sop        <= fwd & sop_b;
      out_eop        <= fwd & eop_b;
      out_err        <= fwd & eop_b & err_b;
      out_frm_err    <= frm;
      out_par_err    <= par_now;
      out_par_sticky <= (out_par_sticky & ~{NUM_LANES{clr_sticky}}) | par_now;
      out_mod        <= (cfg_wide && |(fwd & eop_b)) ? in_mod : '0;
      for (int i = 0; i < NUM_LANES; i++) begin
        if (cfg_wide) out_dat[i*LANE_W +: LANE_W] <= |fwd  ? in_dat[i*LANE_W +: LANE_W] : '0;
        else          out_dat[i*LANE_W +: LANE_W] <= fwd[i] ? in_dat[i*LANE_W +: LANE_W] : '0;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_vld == '0 && out_par_sticky == '0));
  // R5
  wide_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_wide |=> $onehot0(out_vld));
  // R6
  stx_no_data_chk: assert property (@(posedge clk) disable iff (rst)
    stx_take |=> out_vld == '0);
  // R8
  err_needs_eop_chk: assert property (@(posedge clk) disable iff (rst)
    (out_err & ~out_eop) == '0);
  // R10
  mod_on_eop_chk: assert property (@(posedge clk) disable iff (rst)
    (out_mod != '0) |-> (|out_eop));
  // R12
  sticky_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (out_par_err & ~out_par_sticky) == '0);
endmodule

// File: tb/pkt_rx_checker_tb.sv
module pkt_rx_checker_tb;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst, cfg_wide, cfg_even_par, clr_sticky, in_stx;
  logic [31:0] in_dat;
  logic [3:0]  in_par, in_en, in_sop, in_eop, in_err;
  logic [1:0]  in_mod;
  logic [3:0]  out_vld, out_sop, out_eop, out_err, out_frm_err, out_par_err, out_par_sticky;
  logic [31:0] out_dat;
  logic [1:0]  out_mod;

  pkt_rx_checker u_dut (
    .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_even_par(cfg_even_par),
    .clr_sticky(clr_sticky), .in_dat(in_dat), .in_par(in_par), .in_en(in_en),
    .in_stx(in_stx), .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err), .in_mod(in_mod),
    .out_vld(out_vld), .out_dat(out_dat), .out_sop(out_sop), .out_eop(out_eop),
    .out_err(out_err), .out_mod(out_mod), .out_frm_err(out_frm_err),
    .out_par_err(out_par_err), .out_par_sticky(out_par_sticky)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;

  // model state and expected values
  logic [3:0]  m_inpkt, m_sticky;
  logic [1:0]  m_cur;
  logic [3:0]  e_vld, e_sop, e_eop, e_err, e_frm, e_par;
  logic [31:0] e_dat;
  logic [1:0]  e_mod;

  function automatic logic bad_par(logic [31:0] d, int w, logic p, logic ev);
    logic x = p;
    for (int b = 0; b < w; b++) x ^= d[b];
    return x == ev;
  endfunction

  function automatic logic good_par(logic [31:0] d, int w, logic ev);
    logic x = 0;
    for (int b = 0; b < w; b++) x ^= d[b];
    return x ^ ~ev;
  endfunction

  task automatic mbeat(int k, logic s, logic e, logic r, logic [1:0] md);
    logic f;
    if (s) begin
      e_frm[k] = m_inpkt[k]; f = 1; m_inpkt[k] = ~e;
    end else begin
      f = m_inpkt[k]; e_frm[k] = ~m_inpkt[k];
      if (e) m_inpkt[k] = 0;
    end
    if (f) begin
      e_vld[k] = 1; e_sop[k] = s; e_eop[k] = e; e_err[k] = r & e;
      if (cfg_wide) begin e_dat = in_dat; e_mod = e ? md : 2'b00; end
      else e_dat[8*k +: 8] = in_dat[8*k +: 8];
    end
  endtask

  task automatic model();
    {e_vld, e_sop, e_eop, e_err, e_frm, e_par} = '0;
    e_dat = '0; e_mod = '0;
    if (rst) begin m_inpkt = '0; m_sticky = '0; m_cur = '0; return; end
    if (cfg_wide) begin
      if ((in_en[0] | in_stx) && bad_par(in_dat, 32, in_par[0], cfg_even_par)) e_par[0] = 1;
      if (in_en[0]) mbeat(m_cur, in_sop[0], in_eop[0], in_err[0], in_mod);
      else if (in_stx) m_cur = in_dat[1:0];
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (in_en[i]) begin
          if (bad_par(in_dat >> (8*i), 8, in_par[i], cfg_even_par)) e_par[i] = 1;
          mbeat(i, in_sop[i], in_eop[i], in_err[i], in_mod);
        end
      end
    end
    m_sticky = (m_sticky & ~{4{clr_sticky}}) | e_par;
  endtask

  task automatic chk(string tag, string f, logic [31:0] a, logic [31:0] e);
    nchk++;
    if (a !== e) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", tag, f, a, e);
    end
  endtask

  task automatic step(string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    chk(tag, "out_vld", 32'(out_vld), 32'(e_vld));
    chk(tag, "out_dat", out_dat, e_dat);
    chk(tag, "out_sop", 32'(out_sop), 32'(e_sop));
    chk(tag, "out_eop", 32'(out_eop), 32'(e_eop));
    chk(tag, "out_err", 32'(out_err), 32'(e_err));
    chk(tag, "out_mod", 32'(out_mod), 32'(e_mod));
    chk(tag, "out_frm_err", 32'(out_frm_err), 32'(e_frm));
    chk(tag, "out_par_err", 32'(out_par_err), 32'(e_par));
    chk(tag, "out_par_sticky", 32'(out_par_sticky), 32'(m_sticky));
  endtask

  task automatic idle();
    in_en = 0; in_stx = 0; in_sop = 0; in_eop = 0; in_err = 0; in_mod = 0;
    clr_sticky = 0; in_dat = 0; in_par = 0;
  endtask

  // wide beat with parity chosen good or bad
  task automatic wbeat(logic [31:0] d, logic en, logic stx, logic s, logic e,
                       logic r, logic [1:0] md, logic ok);
    idle();
    in_dat = d; in_en[0] = en; in_stx = stx; in_sop[0] = s; in_eop[0] = e;
    in_err[0] = r; in_mod = md;
    in_par[0] = good_par(d, 32, cfg_even_par) ^ ~ok;
  endtask

  task automatic do_reset(logic wide, logic ev);
    idle(); cfg_wide = wide; cfg_even_par = ev; rst = 1;
    step("R1 reset");
    rst = 0;
  endtask

  initial begin
    rst = 1; cfg_wide = 1; cfg_even_par = 0; idle();
    m_inpkt = 0; m_sticky = 0; m_cur = 0;
    @(negedge clk);
    do_reset(1, 0);
    idle(); step("R1 after reset");

    // wide layout: select port 2, three-beat packet
    wbeat(32'h0000_0002, 0, 1, 0, 0, 0, 0, 1); step("R6 select");
    wbeat(32'hA5A5_0001, 1, 0, 1, 0, 0, 0, 1); step("R6 sop");
    wbeat(32'h1234_5678, 1, 0, 0, 0, 1, 0, 1); step("R8 err no eop");
    wbeat(32'hCAFE_0000, 1, 0, 0, 1, 1, 2'b01, 1); step("R10 eop mod");
    // bad parity with no qualifier
    wbeat(32'h0000_0007, 0, 0, 0, 0, 0, 0, 0); step("R4 unqualified");
    // bad parity on select cycle
    wbeat(32'h0000_0001, 0, 1, 0, 0, 0, 0, 0); step("R2 odd bad");
    // other lanes' bits ignored in wide layout
    idle(); in_en = 4'b1110; in_sop = 4'b1110; in_par = 4'b1111; step("R5 upper ignored");
    // framing in wide mode on port 1
    wbeat(32'h1, 1, 0, 0, 0, 0, 0, 1); step("R11 data outside");
    wbeat(32'h2, 1, 0, 1, 0, 0, 0, 1); step("R11 open");
    wbeat(32'h3, 1, 0, 1, 0, 0, 0, 1); step("R11 sop inside");
    wbeat(32'h4, 1, 0, 0, 1, 0, 2'b11, 1); step("R10 close");
    idle(); clr_sticky = 1; step("R12 clear");
    // even sense
    do_reset(1, 1);
    wbeat(32'h0000_0003, 1, 0, 1, 1, 0, 0, 1); step("R3 even good");
    wbeat(32'h0000_0003, 1, 0, 1, 1, 0, 0, 0); step("R3 even bad");
    wbeat(32'h0000_0003, 1, 0, 1, 1, 0, 0, 0); clr_sticky = 1; step("R12 set wins");

    // narrow layout
    do_reset(0, 0);
    idle(); in_en = 4'b0101; in_sop = 4'b0101; in_dat = 32'h44332211;
    for (int i = 0; i < 4; i++) in_par[i] = good_par(in_dat >> (8*i), 8, 0);
    in_stx = 1; step("R7 lanes");
    idle(); in_sop = 4'b1111; in_eop = 4'b1111; in_err = 4'b1111; step("R9 no enable");
    idle(); in_en = 4'b0011; in_eop = 4'b0011; in_err = 4'b0011; in_dat = 32'h00007F80;
    in_par = 4'b0000; step("R8 narrow eop err");
    idle(); in_en = 4'b1000; in_par = 4'b1000; in_dat = 32'h01000000; step("R2 narrow bad");

    // random phases
    for (int ph = 0; ph < 8; ph++) begin
      logic wide;
      wide = ph[0];
      do_reset(wide, ph[1]);
      for (int c = 0; c < 400; c++) begin
        idle();
        in_dat = $urandom;
        in_mod = 2'($urandom);
        clr_sticky = ($urandom % 16) == 0;
        if (wide) begin
          in_en  = 4'($urandom); in_en[0] = ($urandom % 10) < 6;
          in_stx = ~in_en[0] && ($urandom % 4) == 0;
          if (in_stx) in_dat[31:2] = 0;
          in_sop = 4'($urandom); in_sop[0] = ($urandom % 10) < 3;
          in_eop = 4'($urandom); in_eop[0] = ($urandom % 10) < 3;
          in_err = 4'($urandom);
          in_par = 4'($urandom);
          in_par[0] = good_par(in_dat, 32, cfg_even_par) ^ (($urandom % 20) == 0);
        end else begin
          for (int i = 0; i < 4; i++) begin
            in_en[i]  = ($urandom % 10) < 6;
            in_sop[i] = ($urandom % 10) < 3;
            in_eop[i] = ($urandom % 10) < 3;
            in_err[i] = $urandom % 2;
            in_par[i] = good_par(in_dat >> (8*i), 8, cfg_even_par) ^ (($urandom % 20) == 0);
          end
          in_stx = $urandom % 2;
        end
        step("R13 random");
      end
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule